// File: doc/BRIEF.md
# Serial Register Access Port

This block gives a host controller read and write access to a bank of seven 12-bit configuration registers over a three-wire serial link. The block makes the serial clock itself by dividing the system clock by 16, and drives that clock out to the host. When the host holds the enable input high at a rising serial-clock edge, a transfer starts. The following 16 rising edges then sample a frame of 16 bits, least significant bit first. The frame carries a read/write flag, a 3-bit register address and 12 data bits.

A write frame stores its data field in the addressed register. A read frame discards its data field. In its place the block raises a ready strobe for one serial-clock period and then shifts back a 16-bit echo frame: a read flag, the address and the register contents. The serial output has a separate output-enable signal, so the pad can be tri-stated. All outputs change on falling serial-clock edges. The complete register bank, with its reset values, is also presented on a flat output bus for the rest of the chip.

The sequencer has four states. `ST_IDLE` moves to `ST_SHIFT_IN` on a rising edge with the enable high. `ST_SHIFT_IN` takes one bit per rising edge. After the 16th bit it returns to `ST_IDLE` (write) or moves to `ST_ANNOUNCE` (read). `ST_ANNOUNCE` raises the ready strobe at the next falling edge and moves to `ST_SEND`. `ST_SEND` presents one echo bit per falling edge, and after the 16th bit it returns to `ST_IDLE` at the following falling edge.

Top module: `serial_reg_port`

## Requirements
- R1: `sclk_o` is the system clock divided by 16, with 8 system cycles high and 8 low.
- R2: A transfer starts only when `sen` is sampled high at a rising `sclk_o` edge while the port is idle. With `sen` low, the port raises no strobe and changes no register.
- R3: The 16 bits are sampled on the 16 rising edges after the start edge, LSB first. Bit 0 is the direction (1 = read, 0 = write), bits 3:1 are the address and bits 15:4 are the data.
- R4: A write to address k (1 to 7) stores the data field in register k. Register k appears on `regs_o[12k-1:12k-12]`.
- R5: A read leaves every register unchanged, whatever its data bits carry.
- R6: After the 16th capture of a read, `srdy` goes high at the next falling `sclk_o` edge and stays high for exactly one `sclk_o` period.
- R7: At the falling edge where `srdy` drops, `sdo` presents echo bit 0, then one bit per falling edge. The echo frame is 1 in bit 0, the address in bits 3:1 and the register contents in bits 15:4.
- R8: `sdo_oe` follows `sen`, so the serial output is released whenever `sen` is low.
- R9: After reset, register 1 holds 0xD94, register 2 holds 0x800 and register 7 holds 0x07F. All other registers hold 0.
- R10: Address 0 completes the normal handshake. A write to it changes no register, and a read of it returns zero data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sen | input | 1 | Serial enable from the host |
| sdi | input | 1 | Serial data from the host |
| sclk_o | output | 1 | Generated serial clock |
| sdo | output | 1 | Serial echo data |
| sdo_oe | output | 1 | Output enable for the `sdo` pad |
| srdy | output | 1 | Read-ready strobe |
| regs_o | output | 84 | Flat register bank, register 1 in the low 12 bits |

## Verification
The assertions assume that the host changes `sen` and `sdi` only while `sclk_o` is low, so every sample taken at a rising edge sees a settled value. They also assume that the host holds `sen` high through a read until the echo frame is over. The bench drives each bit just after a falling `sclk_o` edge. It keeps `sen` high until the falling edge that follows the last echo bit, and it inserts idle periods with `sen` low between frames, so the assumptions are never broken.

// File: rtl/srap_pkg.sv
`timescale 1ns/1ps
package srap_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SHIFT_IN,
        ST_ANNOUNCE,
        ST_SEND
    } srap_state_e;

    // reset value of each register slot
    function automatic logic [31:0] srap_default(input int unsigned idx);
        unique case (idx)
            1:       return 32'h0000_0D94;
            2:       return 32'h0000_0800;
            7:       return 32'h0000_007F;
            default: return 32'h0;
        endcase
    endfunction

endpackage

// File: rtl/srap_clkgen.sv
`timescale 1ns/1ps
module srap_clkgen #(
    parameter int DIV = 16
) (
    input  logic clk,
    input  logic rst_n,
    output logic sclk,
    output logic rise_tick,
    output logic fall_tick
);
    localparam int CW   = $clog2(DIV);
    localparam int HALF = DIV / 2;

    logic [CW-1:0] cnt;

    assign rise_tick = (cnt == CW'(HALF - 1));
    assign fall_tick = (cnt == CW'(DIV - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt  <= '0;
            sclk <= 1'b0;
        end else begin
            cnt <= fall_tick ? '0 : cnt + 1'b1;
            if (rise_tick)
                sclk <= 1'b1;
            else if (fall_tick)
                sclk <= 1'b0;
        end
    end

    // R1: the serial clock follows the divider ticks
    assert_sclk_rise_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rise_tick |=> sclk);
    assert_sclk_fall_R1: assert property (@(posedge clk) disable iff (!rst_n)
        fall_tick |=> !sclk);

endmodule

// File: rtl/srap_regfile.sv
`timescale 1ns/1ps
module srap_regfile
    import srap_pkg::*;
#(
    parameter int AW = 3,
    parameter int DW = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [AW-1:0]        addr,
    input  logic [DW-1:0]        wr_data,
    output logic [DW-1:0]        rd_data,
    output logic [NREG*DW-1:0]   regs_flat
);
    localparam int NREG = (1 << AW) - 1;

    for (genvar k = 1; k <= NREG; k++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                regs_flat[(k-1)*DW +: DW] <= DW'(srap_default(k));
            else if (wr_en && addr == AW'(k))
                regs_flat[(k-1)*DW +: DW] <= wr_data;
        end
    end

    always_comb begin
        rd_data = '0;
        for (int k = 1; k <= NREG; k++)
            if (addr == AW'(k))
                rd_data = regs_flat[(k-1)*DW +: DW];
    end

    // R10: a write to slot zero leaves the bank untouched
    assert_addr0_inert_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == '0) |=> $stable(regs_flat));

endmodule

// File: rtl/srap_engine.sv
`timescale 1ns/1ps
module srap_engine
    import srap_pkg::*;
#(
    parameter int AW = 3,
    parameter int DW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rise_tick,
    input  logic          fall_tick,
    input  logic          sen,
    input  logic          sdi,
    input  logic [DW-1:0] rd_data,
    output logic          wr_en,
    output logic [AW-1:0] addr,
    output logic [DW-1:0] wr_data,
    output logic          srdy,
    output logic          sdo
);
    localparam int FW = 1 + AW + DW;
    localparam int CW = $clog2(FW + 1);

    srap_state_e   state;
    logic [CW-1:0] cnt;
    logic [FW-1:0] shreg;
    logic [FW-1:0] resp;
    logic [FW-1:0] nxt_word;
    logic          last_in;

    assign nxt_word = {sdi, shreg[FW-1:1]};
    assign last_in  = rise_tick && (state == ST_SHIFT_IN) && (cnt == CW'(FW - 1));
    assign addr     = nxt_word[AW:1];
    assign wr_data  = nxt_word[FW-1:AW+1];
    assign wr_en    = last_in && !nxt_word[0];

    // state register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
            shreg <= '0;
            resp  <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (rise_tick && sen) begin
                        state <= ST_SHIFT_IN;
                        cnt   <= '0;
                    end
                end
                ST_SHIFT_IN: begin
                    if (rise_tick) begin
                        shreg <= nxt_word;
                        cnt   <= cnt + 1'b1;
                        if (last_in) begin
                            if (nxt_word[0]) begin
                                state <= ST_ANNOUNCE;
                                resp  <= {rd_data, addr, 1'b1};
                            end else begin
                                state <= ST_IDLE;
                            end
                        end
                    end
                end
                ST_ANNOUNCE: begin
                    if (fall_tick) begin
                        state <= ST_SEND;
                        cnt   <= '0;
                    end
                end
                ST_SEND: begin
                    if (fall_tick) begin
                        if (cnt == CW'(FW)) begin
                            state <= ST_IDLE;
                        end else begin
                            cnt  <= cnt + 1'b1;
                            resp <= resp >> 1;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // registered outputs, updated on falling serial edges only
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            srdy <= 1'b0;
            sdo  <= 1'b0;
        end else if (fall_tick) begin
            unique case (state)
                ST_ANNOUNCE: begin
                    srdy <= 1'b1;
                    sdo  <= 1'b0;
                end
                ST_SEND: begin
                    srdy <= 1'b0;
                    sdo  <= (cnt < CW'(FW)) ? resp[0] : 1'b0;
                end
                default: begin
                    srdy <= 1'b0;
                    sdo  <= 1'b0;
                end
            endcase
        end
    end

    // R6/R7: outputs move only on a falling serial edge
    assert_out_on_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !fall_tick |=> ($stable(srdy) && $stable(sdo)));
    // R6: the strobe is only seen while the echo is pending
    assert_ready_in_send_R6: assert property (@(posedge clk) disable iff (!rst_n)
        srdy |-> state == ST_SEND);
    // R4: a write closes the frame
    assert_write_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> state == ST_IDLE);
    // R2: no start while the enable is low
    assert_no_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && rise_tick && !sen) |=> state == ST_IDLE);

endmodule

// File: rtl/serial_reg_port.sv
`timescale 1ns/1ps
module serial_reg_port #(
    parameter int DIV = 16,
    parameter int AW  = 3,
    parameter int DW  = 12
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          sen,
    input  logic                          sdi,
    output logic                          sclk_o,
    output logic                          sdo,
    output logic                          sdo_oe,
    output logic                          srdy,
    output logic [((1<<AW)-1)*DW-1:0]     regs_o
);
    logic          rise_tick;
    logic          fall_tick;
    logic          wr_en;
    logic [AW-1:0] addr;
    logic [DW-1:0] wr_data;
    logic [DW-1:0] rd_data;

    assign sdo_oe = sen;

    srap_clkgen #(.DIV(DIV)) u_clk (
        .clk(clk), .rst_n(rst_n), .sclk(sclk_o),
        .rise_tick(rise_tick), .fall_tick(fall_tick)
    );

    srap_engine #(.AW(AW), .DW(DW)) u_eng (
        .clk(clk), .rst_n(rst_n), .rise_tick(rise_tick), .fall_tick(fall_tick),
        .sen(sen), .sdi(sdi), .rd_data(rd_data), .wr_en(wr_en),
        .addr(addr), .wr_data(wr_data), .srdy(srdy), .sdo(sdo)
    );

    srap_regfile #(.AW(AW), .DW(DW)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wr_data(wr_data), .rd_data(rd_data), .regs_flat(regs_o)
    );

endmodule

// File: tb/tb_serial_reg_port.sv
`timescale 1ns/1ps
module tb_serial_reg_port;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sen = 1'b0;
    logic sdi = 1'b0;
    logic sclk_o, sdo, sdo_oe, srdy;
    logic [83:0] regs_o;

    int n_chk = 0;
    int n_err = 0;
    logic [11:0] mdl [0:7];

    always #10 clk = ~clk;

    serial_reg_port dut (
        .clk(clk), .rst_n(rst_n), .sen(sen), .sdi(sdi), .sclk_o(sclk_o),
        .sdo(sdo), .sdo_oe(sdo_oe), .srdy(srdy), .regs_o(regs_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_echo(input logic [2:0] a);
        return {(a == 3'd0) ? 12'h000 : mdl[a], a, 1'b1};
    endfunction

    task automatic check_bank(input string tag);
        for (int k = 1; k < 8; k++)
            check(tag, 32'(regs_o[(k-1)*12 +: 12]), 32'(mdl[k]));
    endtask

    task automatic frame(input logic rd, input logic [2:0] a, input logic [11:0] d,
                         output logic [15:0] got);
        logic [15:0] w;
        w = {d, a, rd};
        got = '0;
        @(negedge sclk_o); #1 sen = 1'b1;
        for (int i = 0; i < 16; i++) begin
            @(negedge sclk_o); #1 sdi = w[i];
        end
        @(negedge sclk_o);
        if (!rd) begin
            #1 sen = 1'b0;
            #100 check("R6 no strobe on write", 32'(srdy), 0);
        end else begin
            #100 check("R6 strobe after last bit", 32'(srdy), 1);
            @(posedge sclk_o); #100 check("R6 strobe held one period", 32'(srdy), 1);
            for (int j = 0; j < 16; j++) begin
                @(negedge sclk_o); #100;
                if (j == 0) check("R6 strobe dropped", 32'(srdy), 0);
                got[j] = sdo;
                sdi = 1'($urandom);
            end
            check("R8 output enabled", 32'(sdo_oe), 1);
            @(negedge sclk_o); #1 sen = 1'b0;
            #1 check("R8 output released", 32'(sdo_oe), 0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        logic [15:0] got;
        realtime t1, t2, t3;
        void'($urandom(32'h5EED));
        for (int k = 0; k < 8; k++) mdl[k] = 12'h000;
        mdl[1] = 12'hD94; mdl[2] = 12'h800; mdl[7] = 12'h07F;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        #5;
        check_bank("R9 reset defaults");
        check("R9 no strobe at reset", 32'(srdy), 0);
        check("R8 released at reset", 32'(sdo_oe), 0);

        // R1 divider
        @(posedge sclk_o); t1 = $realtime;
        @(negedge sclk_o); t2 = $realtime;
        @(posedge sclk_o); t3 = $realtime;
        check("R1 high phase ns", 32'(int'(t2 - t1)), 160);
        check("R1 period ns", 32'(int'(t3 - t1)), 320);

        // R2: enable low, toggling data
        for (int i = 0; i < 20; i++) begin
            @(negedge sclk_o); #1 sdi = 1'($urandom);
            #100 check("R2 idle no strobe", 32'(srdy), 0);
        end
        check_bank("R2 idle no change");

        // R9/R7: read defaults back
        frame(1'b1, 3'd1, 12'hFFF, got);
        check("R7 echo reg1", 32'(got), 32'(exp_echo(3'd1)));
        frame(1'b1, 3'd7, 12'h000, got);
        check("R7 echo reg7", 32'(got), 32'(exp_echo(3'd7)));

        // R3/R4 directed write and read
        frame(1'b0, 3'd5, 12'hA5C, got);
        mdl[5] = 12'hA5C;
        check_bank("R4 write reg5");
        frame(1'b1, 3'd5, 12'h3C3, got);
        check("R3 echo reg5", 32'(got), 32'(exp_echo(3'd5)));
        check_bank("R5 read keeps bank");

        // R10 address zero
        frame(1'b0, 3'd0, 12'hFFF, got);
        check_bank("R10 write addr0 inert");
        frame(1'b1, 3'd0, 12'h123, got);
        check("R10 read addr0 zero", 32'(got), 32'h0001);

        // random mix
        for (int n = 0; n < 24; n++) begin
            logic rd;
            logic [2:0] a;
            logic [11:0] d;
            rd = 1'($urandom);
            a  = 3'($urandom);
            d  = 12'($urandom);
            frame(rd, a, d, got);
            if (rd) begin
                check("R7 random echo", 32'(got), 32'(exp_echo(a)));
                check_bank("R5 random read keeps bank");
            end else begin
                if (a != 3'd0) mdl[a] = d;
                check_bank("R4 random write");
            end
        end

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule